// File: doc/BRIEF.md
# Bridge I/O Window Register Target

This block is the configuration-space target for the I/O forwarding window of a PCI-to-PCI bridge. It holds the window's low base and limit bytes and the secondary status halfword, which share one dword. It also holds a second dword that carries bits 31:16 of the window base and limit. Software reaches both dwords through 32-bit configuration reads and writes. Every write carries four byte enables. The block honours any pattern of them, so a sub-dword write touches only its own lanes. Because of this, updating the window bytes never clears status bits by accident.

Status bits are set by event pulses from the rest of the bridge, and software clears them by writing ones. From the two registers the block builds a 32-bit window and drives a combinational hit flag for any I/O address presented to it. Software can shut the window off temporarily by loading the upper register with a base above the limit.

Top module: `iowin_cfg_regs`

## Requirements
- R1: After reset every register reads as zero. The window then spans 0x0000_0000 up to the limit with its low bits filled with ones (0x0000_0FFF at 4 KB granularity).
- R2: Status bits clear on write-one. Writing 1 to an implemented status bit clears it after the next clock edge, and writing 0 leaves it unchanged.
- R3: A write changes only the byte lanes whose enable is 1. Enable 4'b0000 changes nothing, and non-contiguous patterns such as 4'b0110 and 4'b1001 work lane by lane.
- R4: Dword select 1 is the upper register. Bits 15:0 hold window base bits 31:16, bits 31:16 hold window limit bits 31:16, and all 32 bits are read/write.
- R5: A pulse on an event input bit sets the matching implemented status bit after the next clock edge. If a write-one-to-clear hits that bit in the same cycle, the set wins.
- R6: In dword select 0, lane 0 is the base byte and lane 1 is the limit byte. Each byte carries address bits 15:8 of its window edge. At 4 KB granularity, bits 3:0 of each byte read as zero. At 1 KB granularity, bits 1:0 read as zero.
- R7: The implemented status bits are those set in the mask (default 16'hF900). All other status bits read as zero whatever is written or signalled.
- R8: The hit flag is 1 exactly when the address is at or above {upper base, base byte, 8'h00}. It must also be at or below {upper limit, limit byte with its unwritable bits set to one, 8'hFF}.
- R9: Writing 32'h0000_FFFF to the upper register puts the base above the limit, and the hit flag is then 0 for every address.
- R10: The read data always shows the current contents of the selected dword. Select 0 returns {status, limit byte, base byte}, and select 1 returns the upper register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe, one cycle per write |
| cfg_sel | input | 1 | Dword select: 0 window/status dword, 1 upper dword |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the selected dword (combinational) |
| stat_evt | input | 16 | Status event pulses, one per status bit |
| io_addr | input | 32 | I/O address to test against the window |
| io_hit | output | 1 | Address lies within the window |

## Verification
A write or an event pulse becomes visible on the read data, and in the hit flag, one cycle later: it is captured at the rising edge where it is presented. Read data and the hit flag follow the select and address inputs within the same cycle. The bench therefore drives at the falling edge and lets one rising edge pass. It then changes the select or the address at the next falling edge and samples shortly after, with no clock edge in between. The set-versus-clear collision is checked by presenting both stimuli in the same cycle.

// File: rtl/iowin_cfg_regs.sv
module iowin_cfg_regs #(
  parameter bit          GRAN_1K   = 1'b0,
  parameter logic [15:0] STAT_IMPL = 16'hF900
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic        cfg_sel,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic [15:0] stat_evt,
  input  logic [31:0] io_addr,
  output logic        io_hit
);
  localparam logic [7:0] WIN_MASK = GRAN_1K ? 8'hFC : 8'hF0;

  logic [7:0]  base_q, lim_q;
  logic [15:0] stat_q;
  logic [31:0] up_q;

  logic        wr_lo, wr_up;
  logic [15:0] clr_vec, set_vec;
  logic [31:0] win_lo, win_hi;

  assign wr_lo   = cfg_wr & ~cfg_sel;
  assign wr_up   = cfg_wr &  cfg_sel;
  assign clr_vec = {{8{wr_lo & cfg_be[3]}}, {8{wr_lo & cfg_be[2]}}} & cfg_wdata[31:16];
  assign set_vec = stat_evt & STAT_IMPL;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      lim_q  <= '0;
      stat_q <= '0;
      up_q   <= '0;
    end else begin
      if (wr_lo && cfg_be[0]) base_q <= cfg_wdata[7:0]  & WIN_MASK;
      if (wr_lo && cfg_be[1]) lim_q  <= cfg_wdata[15:8] & WIN_MASK;
      stat_q <= (stat_q & ~clr_vec) | set_vec;
      for (int i = 0; i < 4; i++)
        if (wr_up && cfg_be[i]) up_q[8*i +: 8] <= cfg_wdata[8*i +: 8];
    end
  end

  assign cfg_rdata = cfg_sel ? up_q : {stat_q, lim_q, base_q};

  assign win_lo = {up_q[15:0],  base_q,             8'h00};
  assign win_hi = {up_q[31:16], lim_q | ~WIN_MASK,  8'hFF};
  assign io_hit = (io_addr >= win_lo) && (io_addr <= win_hi);

  a_r3_base_lane_held: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr && !cfg_sel && cfg_be[0]) |=> $stable(base_q));

  a_r3_limit_lane_held: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr && !cfg_sel && cfg_be[1]) |=> $stable(lim_q));

  a_r4_upper_held: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr && cfg_sel) |=> $stable(up_q));

  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != 16'h0) |=> ((stat_q & $past(set_vec)) == $past(set_vec)));

  a_r2_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec != 16'h0) |=> ((stat_q & $past(clr_vec & ~set_vec)) == 16'h0));

  a_r7_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_sel |-> ((cfg_rdata[31:16] & ~STAT_IMPL) == 16'h0));

  a_r9_disabled_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q[15:0] > up_q[31:16]) |-> !io_hit);
endmodule

// File: tb/iowin_cfg_regs_bench.sv
`timescale 1ns/100ps
module iowin_cfg_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0, cfg_sel = 1'b0;
  logic [3:0]  cfg_be = 4'h0;
  logic [31:0] cfg_wdata = '0;
  logic [15:0] stat_evt = '0;
  logic [31:0] io_addr = '0;
  logic [31:0] cfg_rdata, rdata_k;
  logic        io_hit, hit_k;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  iowin_cfg_regs u_iowin_cfg_regs (
    .clk, .rst_n, .cfg_wr, .cfg_sel, .cfg_be, .cfg_wdata,
    .cfg_rdata, .stat_evt, .io_addr, .io_hit);

  iowin_cfg_regs #(.GRAN_1K(1'b1)) u_iowin_cfg_regs_1k (
    .clk, .rst_n, .cfg_wr, .cfg_sel, .cfg_be, .cfg_wdata,
    .cfg_rdata(rdata_k), .stat_evt, .io_addr, .io_hit(hit_k));

  // {sel, be, wdata, expected read of same dword}
  localparam logic [68:0] VEC [8] = '{
    {1'b0, 4'b1111, 32'h0000_F3A5, 32'h0000_F0A0},  // R6 R3 full dword, low nibbles masked
    {1'b0, 4'b0001, 32'hFFFF_FF12, 32'h0000_F010},  // R3 lane 0 only
    {1'b0, 4'b0010, 32'h0000_2233, 32'h0000_2010},  // R3 lane 1 only
    {1'b1, 4'b1111, 32'h1234_5678, 32'h1234_5678},  // R4 R10 upper dword
    {1'b1, 4'b0110, 32'hAABB_CCDD, 32'h12BB_CC78},  // R3 non-contiguous middle
    {1'b1, 4'b1001, 32'h0011_2200, 32'h00BB_CC00},  // R3 outer lanes
    {1'b0, 4'b0000, 32'hFFFF_FFFF, 32'h0000_2010},  // R3 no lanes
    {1'b0, 4'b0110, 32'hFFFF_5500, 32'h0000_5010}   // R3 limit lane, status lane zeros
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic sel, logic [3:0] be, logic [31:0] d, logic [15:0] ev = 16'h0);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_be = be; cfg_wdata = d; stat_evt = ev;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = 4'h0; stat_evt = 16'h0;
  endtask

  task automatic rd(logic sel, string req, logic [31:0] exp);
    cfg_sel = sel; #1;
    chk(req, cfg_rdata, exp);
  endtask

  task automatic hit(logic [31:0] a, logic exp, string req);
    io_addr = a; #1;
    chk(req, {31'h0, io_hit}, {31'h0, exp});
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(1'b0, "R1 dword0 reset", 32'h0);
    rd(1'b1, "R1 dword1 reset", 32'h0);
    hit(32'h0000_0800, 1'b1, "R1 reset window inside");
    hit(32'h0000_1000, 1'b0, "R1 reset window above");

    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][68], VEC[i][67:64], VEC[i][63:32]);
      rd(VEC[i][68], "R3 R4 R6 vector", VEC[i][31:0]);
    end

    wr(1'b0, 4'b0000, 32'h0, 16'hFFFF);
    rd(1'b0, "R5 R7 events set implemented bits", 32'hF900_5010);
    wr(1'b0, 4'b1000, 32'h8000_0000);
    rd(1'b0, "R2 write one clears", 32'h7900_5010);
    wr(1'b0, 4'b0100, 32'h0000_0000);
    rd(1'b0, "R2 write zero keeps", 32'h7900_5010);
    wr(1'b0, 4'b1100, 32'h0100_FFFF);
    rd(1'b0, "R2 R3 clear bit8 window untouched", 32'h7800_5010);
    wr(1'b0, 4'b1100, 32'h0800_0000, 16'h0800);
    rd(1'b0, "R5 set wins over clear", 32'h7800_5010);
    wr(1'b0, 4'b1100, 32'h0800_0000);
    rd(1'b0, "R2 clear after collision", 32'h7000_5010);
    wr(1'b0, 4'b1100, 32'h06FF_0000);
    rd(1'b0, "R7 unimplemented bits stay zero", 32'h7000_5010);

    hit(32'hCC00_3000, 1'b0, "R9 base upper above limit upper");
    wr(1'b1, 4'b1111, 32'h0002_0001);
    hit(32'h0001_1000, 1'b1, "R8 at base");
    hit(32'h0001_0FFF, 1'b0, "R8 below base");
    hit(32'h0002_5FFF, 1'b1, "R8 at limit");
    hit(32'h0002_6000, 1'b0, "R8 above limit");
    wr(1'b1, 4'b1111, 32'h0000_FFFF);
    hit(32'h0001_1000, 1'b0, "R9 disable pattern");
    hit(32'h0000_0000, 1'b0, "R9 disable pattern zero");
    wr(1'b1, 4'b1111, 32'h0001_0001);
    hit(32'h0001_5FFF, 1'b1, "R8 same upper limit");

    wr(1'b0, 4'b0011, 32'h0000_FFFF);
    cfg_sel = 1'b0; #1;
    chk("R6 1K granularity read", rdata_k, 32'h7000_FCFC);
    io_addr = 32'h0001_FC00; #1;
    chk("R6 R8 1K base edge", {31'h0, hit_k}, 32'h1);
    io_addr = 32'h0001_FBFF; #1;
    chk("R6 R8 1K below base", {31'h0, hit_k}, 32'h0);
    rd(1'b0, "R6 4K granularity read", 32'h7000_F0F0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule